// File: doc/BRIEF.md
# Pipelined Photon Count Summation Tree

This block collapses the per-symbol photon counts of a single-photon detector array into sample words for an optical receiver. The array has 1024 detectors arranged in 256 groups of four. Each group delivers a 6-bit count for the current symbol period. The groups are split into 16 data channels, and each channel covers the area lit by one fibre strand. A register-per-level tree of parallel adders first forms one sum per channel. It then combines those sums into one total for the whole array. One word leaves on a 14-bit bus for every symbol presented.

A mode input chooses what the bus carries. In the default mode it carries the total over all detectors. In the other mode it carries the sum of one channel, picked by a 4-bit index and zero-extended. The mode and the index travel through the pipeline alongside the counts they were captured with. A new word appears a fixed eight cycles after its input set. A new input set may be offered on every cycle.

Top module: `photon_sum_tree`

## Requirements
- R1: While reset is asserted and after it is released, with no input set yet accepted, `out_valid` is 0 and `out_word` is 0.
- R2: `out_valid` rises exactly 8 clock cycles after the cycle in which `in_valid` was sampled high, once per accepted input set.
- R3: With `chan_mode` = 0 the result is the sum of all 256 group counts. Group g occupies bits `grp_counts[6*g+5 : 6*g]`.
- R4: With `chan_mode` = 1 the result is the sum of groups 16*c to 16*c+15, where c is `chan_idx`. The sum is zero-extended to 14 bits, so bits 13..10 are 0.
- R5: When every count is 63 the global result is 16128 and a channel result is 1008, with no wrap-around.
- R6: Cycles with `in_valid` low are ignored. After results drain, `out_valid` stays 0 and `out_word` keeps its last value whatever the other inputs do.
- R7: `chan_mode` and `chan_idx` are captured together with the counts. Changing them while `in_valid` is low does not alter any result already in flight.
- R8: Input sets offered on consecutive cycles give results on consecutive cycles, in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | High when `grp_counts`, `chan_mode` and `chan_idx` form a new input set |
| grp_counts | input | 1536 | 256 packed 6-bit group counts, group 0 in the low bits |
| chan_mode | input | 1 | 0: global total, 1: single channel sum |
| chan_idx | input | 4 | Channel chosen when `chan_mode` is 1 |
| out_valid | output | 1 | High for one cycle per result |
| out_word | output | 14 | Sample word; holds its value between results |

## Verification
The in-line properties assume that every count is a full 6-bit value with no unknown bits. They also assume that `chan_idx` always names one of the 16 channels. Under those conditions no level of the tree can wrap, and the total over each stage's outputs must equal the total over its inputs one cycle earlier. The stimulus meets these conditions in two ways. It builds every count by reducing a generated value modulo 64. It drives all inputs to defined values from time zero, even on idle cycles.

// File: rtl/photon_sum_pkg.sv
package photon_sum_pkg;

    localparam int DEF_GROUPS   = 256;
    localparam int DEF_CHANNELS = 16;
    localparam int DEF_CNT_W    = 6;
    localparam int DEF_OUT_W    = 14;

    // Start index (in lanes) of tree level lvl inside the flat lane bus,
    // where level 0 holds n lanes and every level halves the lane count.
    function automatic int level_offset(input int n, input int lvl);
        return 2 * n - ((2 * n) >> lvl);
    endfunction

endpackage

// File: rtl/photon_pair_stage.sv
module photon_pair_stage #(
    parameter int N_IN = 2,
    parameter int W    = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_i,
    input  logic [N_IN*W-1:0]       vals_i,
    output logic [(N_IN/2)*W-1:0]   sums_o
);

    localparam int N_OUT = N_IN / 2;

    typedef struct packed {
        logic [N_OUT-1:0][W-1:0] sums;
    } pair_st_t;

    pair_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_i) begin
            for (int k = 0; k < N_OUT; k++) begin
                st_d.sums[k] = vals_i[(2*k)*W +: W] + vals_i[(2*k+1)*W +: W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sums_o = st_q.sums;

    // Conservation check: totals across the stage boundary.
    localparam int TW = W + $clog2(N_IN) + 1;
    logic [TW-1:0] in_total;
    logic [TW-1:0] out_total;

    always_comb begin
        in_total  = '0;
        out_total = '0;
        for (int k = 0; k < N_IN; k++) begin
            in_total = in_total + TW'(vals_i[k*W +: W]);
        end
        for (int k = 0; k < N_OUT; k++) begin
            out_total = out_total + TW'(st_q.sums[k]);
        end
    end

    // R3
    sum_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> (out_total == $past(in_total)));

endmodule

// File: rtl/photon_side_pipe.sv
module photon_side_pipe #(
    parameter int LEVELS = 8,
    parameter int TAP    = 4,
    parameter int CIDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic              mode_i,
    input  logic [CIDX_W-1:0] chan_i,
    output logic [LEVELS:0]   valid_o,
    output logic [CIDX_W-1:0] chan_tap_o,
    output logic              mode_out_o
);

    typedef struct packed {
        logic [LEVELS:1]             vld;
        logic [LEVELS:1]             mode;
        logic [TAP:1][CIDX_W-1:0]    chan;
    } side_st_t;

    side_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.vld[1] = valid_i;
        if (valid_i) begin
            st_d.mode[1] = mode_i;
            st_d.chan[1] = chan_i;
        end
        for (int k = 2; k <= LEVELS; k++) begin
            st_d.vld[k] = st_q.vld[k-1];
            if (st_q.vld[k-1]) begin
                st_d.mode[k] = st_q.mode[k-1];
            end
        end
        for (int k = 2; k <= TAP; k++) begin
            if (st_q.vld[k-1]) begin
                st_d.chan[k] = st_q.chan[k-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o    = {st_q.vld, valid_i};
    assign chan_tap_o = st_q.chan[TAP];
    assign mode_out_o = st_q.mode[LEVELS];

    // R7
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.vld[LEVELS-1] |=> $stable(mode_out_o));

endmodule

// File: rtl/photon_chan_pick.sv
module photon_chan_pick #(
    parameter int N_CHAN = 16,
    parameter int W      = 14,
    parameter int CH_W   = 10,
    parameter int DEPTH  = 4,
    parameter int CIDX_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DEPTH-1:0]     en_i,
    input  logic [CIDX_W-1:0]    chan_i,
    input  logic [N_CHAN*W-1:0]  sums_i,
    output logic [W-1:0]         pick_o
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] stg;
    } pick_st_t;

    pick_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_i[0]) begin
            st_d.stg[0] = sums_i[int'(chan_i)*W +: W];
        end
        for (int k = 1; k < DEPTH; k++) begin
            if (en_i[k]) begin
                st_d.stg[k] = st_q.stg[k-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pick_o = st_q.stg[DEPTH-1];

    // R4
    chan_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_o >> CH_W) == '0);

endmodule

// File: rtl/photon_sum_tree.sv
module photon_sum_tree
    import photon_sum_pkg::*;
#(
    parameter int N_GROUPS = DEF_GROUPS,
    parameter int N_CHAN   = DEF_CHANNELS,
    parameter int CNT_W    = DEF_CNT_W,
    parameter int OUT_W    = DEF_OUT_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [N_GROUPS*CNT_W-1:0]     grp_counts,
    input  logic                          chan_mode,
    input  logic [$clog2(N_CHAN)-1:0]     chan_idx,
    output logic                          out_valid,
    output logic [OUT_W-1:0]              out_word
);

    localparam int LEVELS     = $clog2(N_GROUPS);
    localparam int CH_LVLS    = $clog2(N_GROUPS / N_CHAN);
    localparam int PICK_DEPTH = LEVELS - CH_LVLS;
    localparam int CIDX_W     = $clog2(N_CHAN);
    localparam int CH_W       = CNT_W + CH_LVLS;
    localparam int LANES      = 2 * N_GROUPS - 1;
    localparam int MAX_TOTAL  = N_GROUPS * ((1 << CNT_W) - 1);
    localparam int CH_OFF     = level_offset(N_GROUPS, CH_LVLS);
    localparam int TOP_OFF    = level_offset(N_GROUPS, LEVELS);

    logic [LANES*OUT_W-1:0] lane_bus;
    logic [LEVELS:0]        stg_valid;
    logic [CIDX_W-1:0]      chan_at_tap;
    logic                   mode_at_out;
    logic [OUT_W-1:0]       chan_word;
    logic [OUT_W-1:0]       total_word;

    // Level 0: widen every group count to a full output lane.
    for (genvar g = 0; g < N_GROUPS; g++) begin : g_lane0
        assign lane_bus[g*OUT_W +: OUT_W] = OUT_W'(grp_counts[g*CNT_W +: CNT_W]);
    end

    // One registered pairwise adder stage per tree level.
    for (genvar l = 1; l <= LEVELS; l++) begin : g_level
        localparam int IN_OFF  = level_offset(N_GROUPS, l - 1);
        localparam int OUT_OFF = level_offset(N_GROUPS, l);
        localparam int N_IN    = N_GROUPS >> (l - 1);

        photon_pair_stage #(
            .N_IN (N_IN),
            .W    (OUT_W)
        ) u_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (stg_valid[l-1]),
            .vals_i (lane_bus[IN_OFF*OUT_W +: N_IN*OUT_W]),
            .sums_o (lane_bus[OUT_OFF*OUT_W +: (N_IN/2)*OUT_W])
        );
    end

    photon_side_pipe #(
        .LEVELS (LEVELS),
        .TAP    (CH_LVLS),
        .CIDX_W (CIDX_W)
    ) u_side (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_i    (in_valid),
        .mode_i     (chan_mode),
        .chan_i     (chan_idx),
        .valid_o    (stg_valid),
        .chan_tap_o (chan_at_tap),
        .mode_out_o (mode_at_out)
    );

    photon_chan_pick #(
        .N_CHAN (N_CHAN),
        .W      (OUT_W),
        .CH_W   (CH_W),
        .DEPTH  (PICK_DEPTH),
        .CIDX_W (CIDX_W)
    ) u_pick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (stg_valid[LEVELS-1:CH_LVLS]),
        .chan_i (chan_at_tap),
        .sums_i (lane_bus[CH_OFF*OUT_W +: N_CHAN*OUT_W]),
        .pick_o (chan_word)
    );

    assign total_word = lane_bus[TOP_OFF*OUT_W +: OUT_W];
    assign out_valid  = stg_valid[LEVELS];
    assign out_word   = mode_at_out ? chan_word : total_word;

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(total_word) <= MAX_TOTAL));

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stg_valid[LEVELS-1] |=> ($stable(out_word) && !out_valid));

endmodule

// File: tb/photon_sum_tree_bench.sv
module photon_sum_tree_bench;

    localparam int NG  = 256;
    localparam int CW  = 6;
    localparam int OW  = 14;
    localparam int LAT = 8;

    typedef struct packed {
        int   pat;
        int   seed;
        logic mode;
        int   chan;
    } vec_t;

    // pat: 0 zero, 1 all max, 2 g%64, 3 single group 'seed' at 63,
    //      4 hashed, 5 only channel 'seed' at max
    localparam vec_t VECS [12] = '{
        '{0, 0,   1'b0, 0},
        '{1, 0,   1'b0, 0},
        '{1, 0,   1'b1, 15},
        '{2, 0,   1'b0, 0},
        '{2, 0,   1'b1, 0},
        '{2, 0,   1'b1, 9},
        '{3, 200, 1'b0, 0},
        '{3, 200, 1'b1, 12},
        '{3, 200, 1'b1, 11},
        '{4, 7,   1'b0, 0},
        '{4, 13,  1'b1, 6},
        '{5, 3,   1'b0, 0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [NG*CW-1:0]  grp_counts = '0;
    logic              chan_mode = 1'b0;
    logic [3:0]        chan_idx = '0;
    logic              out_valid;
    logic [OW-1:0]     out_word;

    int    errs = 0;
    int    checks = 0;
    int    cyc = 0;
    int    n_sent = 0;
    int    n_seen = 0;
    int    exp_val [64];
    int    in_cyc  [64];
    string lbl     [64];

    photon_sum_tree u_photon_sum_tree (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .grp_counts (grp_counts),
        .chan_mode  (chan_mode),
        .chan_idx   (chan_idx),
        .out_valid  (out_valid),
        .out_word   (out_word)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic ok, input int act, input int expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic logic [NG*CW-1:0] gen_counts(input int pat, input int seed);
        logic [NG*CW-1:0] v;
        v = '0;
        for (int g = 0; g < NG; g++) begin
            int c;
            case (pat)
                1:       c = 63;
                2:       c = g % 64;
                3:       c = (g == seed) ? 63 : 0;
                4:       c = (g * seed + 3) % 64;
                5:       c = (g / 16 == seed) ? 63 : 0;
                default: c = 0;
            endcase
            v[g*CW +: CW] = CW'(c);
        end
        return v;
    endfunction

    function automatic int model(input logic [NG*CW-1:0] cnt, input logic mode, input int chan);
        int s;
        s = 0;
        for (int g = 0; g < NG; g++) begin
            if (!mode || (g / 16 == chan)) s += int'(cnt[g*CW +: CW]);
        end
        return s;
    endfunction

    task automatic send(input logic [NG*CW-1:0] cnt, input logic mode, input int chan, input string tag);
        @(negedge clk);
        in_valid   = 1'b1;
        grp_counts = cnt;
        chan_mode  = mode;
        chan_idx   = 4'(chan);
        exp_val[n_sent] = model(cnt, mode, chan);
        in_cyc[n_sent]  = cyc;
        lbl[n_sent]     = tag;
        n_sent++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Result monitor: value (R3/R4/R5/R7) and latency (R2), in order (R8)
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (n_seen < n_sent) begin
                check(lbl[n_seen], out_word == OW'(exp_val[n_seen]), int'(out_word), exp_val[n_seen]);
                check("R2 latency", (cyc - in_cyc[n_seen]) == LAT, cyc - in_cyc[n_seen], LAT);
            end else begin
                check("R2 extra result", 1'b0, n_seen, n_sent);
            end
            n_seen++;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check("watchdog", 1'b0, cyc, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int held;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 valid in reset", out_valid == 1'b0, int'(out_valid), 0);
        check("R1 word in reset", out_word == '0, int'(out_word), 0);
        rst_n = 1'b1;
        idle(3);
        check("R1 valid after reset", out_valid == 1'b0, int'(out_valid), 0);
        check("R1 word after reset", out_word == '0, int'(out_word), 0);

        // Table walk, back to back on consecutive cycles (R8)
        for (int i = 0; i < 12; i++) begin
            string tag;
            tag = VECS[i].mode ? "R4" : "R3";
            if (VECS[i].pat == 1) tag = "R5";
            send(gen_counts(VECS[i].pat, VECS[i].seed), VECS[i].mode, VECS[i].chan, tag);
        end
        idle(LAT + 4);

        // R6: idle cycles with busy inputs must leave the output alone
        held = int'(out_word);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check("R6 no valid", out_valid == 1'b0, int'(out_valid), 0);
            check("R6 word held", int'(out_word) == held, int'(out_word), held);
            in_valid   = 1'b0;
            grp_counts = gen_counts(4, i + 2);
            chan_mode  = ~chan_mode;
            chan_idx   = 4'(i);
        end

        // R7: sideband changes between valid sets do not reach results in flight
        send(gen_counts(4, 5), 1'b1, 5, "R7 channel kept");
        @(negedge clk);
        in_valid   = 1'b0;
        chan_mode  = 1'b0;
        chan_idx   = 4'd0;
        grp_counts = gen_counts(1, 0);
        @(negedge clk);
        chan_mode  = 1'b1;
        chan_idx   = 4'd2;
        send(gen_counts(2, 0), 1'b0, 0, "R7 global kept");
        @(negedge clk);
        in_valid  = 1'b0;
        chan_mode = 1'b1;
        chan_idx  = 4'd15;
        idle(LAT + 4);

        check("R2 result count", n_seen == n_sent, n_seen, n_sent);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule